// File: doc/BRIEF.md
# Serial SAR Converter Control Sequencer

This block is the digital controller of a 12-bit successive-approximation converter that delivers its result over a three-wire serial link. It runs entirely from the serial clock. It drives a trial code into the capacitive DAC, reads back a single comparator decision per clock, and shifts the frame out on `ser_data`. That frame holds four zero bits followed by the twelve result bits, most significant first. Each result bit is decided by the comparator exactly one clock before it appears on the serial output. No result register sits between the decision and the output.

A high level on `sel_n` clears the whole conversion engine asynchronously. While `sel_n` is high the sample/hold stays in sample mode and the output driver is disabled. Two modes follow from how the host drives `sel_n`:

- **Select-per-conversion mode:** a host that pulses `sel_n` high between words gets one conversion per select.
- **Free-running mode:** a host that holds `sel_n` low gets back-to-back frames. Each 16-clock frame is followed by one dead clock, so frames repeat every 17 clocks.

`pwr_down` clears the engine in the same way. It also restarts a power-up counter. Until that counter has counted `PU_CLKS` falling edges, any request to start a conversion is ignored.

Top module: `sar_serial_seq`

## Requirements
- R1: While `sel_n` or `pwr_down` is high, `conv_busy`, `sh_hold`, `ser_data` and `ser_data_oe` are all 0, with no clock needed.
- R2: When both clears are low, power-up has completed and no conversion is running, the next falling edge of `ser_clk` starts a conversion: `conv_busy` and `sh_hold` become 1 after that edge.
- R3: A frame has 16 slots. Slot 0 begins at the start edge, and each later slot begins at the next falling edge. `ser_data` is 0 in slots 0 to 3. In slot 4+k it carries result bit 11-k, so the result goes out MSB first and is stable at each rising edge.
- R4: `conv_busy` stays 1 for exactly 16 clocks. It falls at the falling edge that ends slot 15.
- R5: With `sel_n` held low, one dead clock follows each frame. During it `conv_busy` is 0 and `ser_data` is 0. The next falling edge starts a new frame, so frames repeat every 17 clocks.
- R6: During slot 3+(11-i), `dac_code` presents the trial code for bit i: bits above i as already decided, bit i set to 1, and bits below i set to 0. Outside slots 3 to 14, `dac_code` shows the decided bits with no trial bit set.
- R7: A bit is kept as 1 only when `cmp_ge` is 1, meaning the input is at or above the trial level. The 12 result bits therefore equal the sampled input code, including the codes 0x000 and 0xFFF.
- R8: Raising `pwr_down` during a conversion aborts it at once: `conv_busy`, `sh_hold` and `ser_data_oe` drop to 0.
- R9: After `pwr_down` falls, no conversion can start until `PU_CLKS` falling edges (default 8) have passed. The earliest start is falling edge `PU_CLKS`+1. A select pulse that lies wholly inside the window starts nothing.
- R10: `ser_data_oe` goes to 1 at the first start edge and stays 1, including through dead clocks, until a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ser_clk | input | 1 | Serial clock; all state changes on its falling edge |
| sel_n | input | 1 | Active-low select; high clears the engine asynchronously |
| pwr_down | input | 1 | Active-high power-down; clears the engine and restarts the power-up count |
| cmp_ge | input | 1 | Comparator decision: 1 when the input is at or above `dac_code` |
| dac_code | output | 12 | Trial code driven into the DAC |
| ser_data | output | 1 | Serial result bit |
| ser_data_oe | output | 1 | Output-enable for the serial data pad driver |
| conv_busy | output | 1 | High while a frame is in progress |
| sh_hold | output | 1 | 1 = hold, 0 = sample |

## Verification
The assertions assume that `ser_clk` runs without gaps. They also assume that `sel_n` and `pwr_down` change only away from the falling edge, and that `cmp_ge` has settled from `dac_code` before the next falling edge. The bench meets these assumptions as follows:

- It drives every input just after a rising edge, half a period from the active edge.
- It models the comparator as a combinational compare of `dac_code` against a stored code.
- It changes that stored code only while no bit trial is running.

// File: rtl/sar_serial_pkg.sv
package sar_serial_pkg;

  typedef enum logic {
    PH_WAIT = 1'b0,
    PH_CONV = 1'b1
  } phase_e;

  // Trial word for bit 'idx': keep bits above idx, set idx, clear below.
  function automatic logic [31:0] trial_word(input logic [31:0] kept,
                                             input logic [31:0] idx);
    logic [31:0] at_bit;
    logic [31:0] low_mask;
    at_bit   = 32'd1 << idx;
    low_mask = at_bit - 32'd1;
    return (kept & ~(low_mask | at_bit)) | at_bit;
  endfunction

  // Slot number to result-bit index: the last decision slot maps to bit 0.
  function automatic logic [31:0] slot_to_bit(input logic [31:0] slot,
                                              input logic [31:0] last_dec);
    return last_dec - slot;
  endfunction

endpackage

// File: rtl/sar_serial_pwrgate.sv
module sar_serial_pwrgate #(
  parameter int PU_CLKS = 8
) (
  input  logic ser_clk,
  input  logic pwr_down,
  output logic pu_done
);
  generate
    if (PU_CLKS == 0) begin : g_nowait
      assign pu_done = 1'b1;
    end else begin : g_count
      localparam int PW = $clog2(PU_CLKS + 1);
      localparam logic [PW-1:0] PU_LIM = PW'(PU_CLKS);
      logic [PW-1:0] pu_cnt;
      always_ff @(negedge ser_clk or posedge pwr_down) begin
        if (pwr_down)
          pu_cnt <= '0;
        else if (pu_cnt != PU_LIM)
          pu_cnt <= pu_cnt + 1'b1;
      end
      assign pu_done = (pu_cnt == PU_LIM);
    end
  endgenerate
endmodule

// File: rtl/sar_serial_framer.sv
module sar_serial_framer
  import sar_serial_pkg::*;
#(
  parameter int FRAME = 16,
  parameter int CW    = $clog2(FRAME)
) (
  input  logic          ser_clk,
  input  logic          clr,
  input  logic          start_ok,
  output logic          busy,
  output logic [CW-1:0] slot,
  output logic          start_ev
);
  localparam logic [CW-1:0] LAST_SLOT = CW'(FRAME - 1);

  phase_e phase;

  always_ff @(negedge ser_clk or posedge clr) begin
    if (clr) begin
      phase <= PH_WAIT;
      slot  <= '0;
    end else begin
      unique case (phase)
        PH_WAIT: begin
          slot <= '0;
          if (start_ok) phase <= PH_CONV;
        end
        PH_CONV: begin
          if (slot == LAST_SLOT) begin
            phase <= PH_WAIT;
            slot  <= '0;
          end else begin
            slot <= slot + 1'b1;
          end
        end
        default: phase <= PH_WAIT;
      endcase
    end
  end

  assign busy     = (phase == PH_CONV);
  assign start_ev = (phase == PH_WAIT) && start_ok;
endmodule

// File: rtl/sar_serial_sar.sv
module sar_serial_sar
  import sar_serial_pkg::*;
#(
  parameter int RES  = 12,
  parameter int LEAD = 4,
  parameter int CW   = 4
) (
  input  logic           ser_clk,
  input  logic           clr,
  input  logic           start_ev,
  input  logic           busy,
  input  logic [CW-1:0]  slot,
  input  logic           cmp_ge,
  output logic           decide_ev,
  output logic [RES-1:0] dac_code,
  output logic [RES-1:0] result
);
  // Bit i is decided in the slot just before it is shifted out.
  localparam int IW = (RES > 1) ? $clog2(RES) : 1;
  localparam logic [CW-1:0] DEC_FIRST = CW'(LEAD - 1);
  localparam logic [CW-1:0] DEC_LAST  = CW'(LEAD + RES - 2);

  logic [IW-1:0]  bit_idx;
  logic [RES-1:0] trial;

  assign decide_ev = busy && (slot >= DEC_FIRST) && (slot <= DEC_LAST);
  assign bit_idx   = IW'(slot_to_bit(32'(slot), 32'(DEC_LAST)));
  assign trial     = RES'(trial_word(32'(result), 32'(bit_idx)));
  assign dac_code  = decide_ev ? trial : result;

  always_ff @(negedge ser_clk or posedge clr) begin
    if (clr)
      result <= '0;
    else if (start_ev)
      result <= '0;
    else if (decide_ev)
      result[bit_idx] <= cmp_ge;
  end
endmodule

// File: rtl/sar_serial_shifter.sv
module sar_serial_shifter (
  input  logic ser_clk,
  input  logic clr,
  input  logic start_ev,
  input  logic decide_ev,
  input  logic cmp_ge,
  output logic ser_data,
  output logic ser_data_oe
);
  // The fresh decision goes straight to the pin; every other slot sends 0.
  always_ff @(negedge ser_clk or posedge clr) begin
    if (clr) begin
      ser_data    <= 1'b0;
      ser_data_oe <= 1'b0;
    end else begin
      ser_data <= decide_ev & cmp_ge;
      if (start_ev) ser_data_oe <= 1'b1;
    end
  end
endmodule

// File: rtl/sar_serial_seq.sv
module sar_serial_seq #(
  parameter int RES     = 12,
  parameter int LEAD    = 4,
  parameter int PU_CLKS = 8
) (
  input  logic           ser_clk,
  input  logic           sel_n,
  input  logic           pwr_down,
  input  logic           cmp_ge,
  output logic [RES-1:0] dac_code,
  output logic           ser_data,
  output logic           ser_data_oe,
  output logic           conv_busy,
  output logic           sh_hold
);
  // LEAD must be at least 1: the first decision uses the last lead slot.
  localparam int FRAME = RES + LEAD;
  localparam int CW    = $clog2(FRAME);

  logic          clr;
  logic          pu_done;
  logic          busy;
  logic [CW-1:0] slot;
  logic          start_ev;
  logic          decide_ev;
  logic [RES-1:0] result;

  assign clr = sel_n | pwr_down;

  sar_serial_pwrgate #(.PU_CLKS(PU_CLKS)) u_pwr (
    .ser_clk (ser_clk),
    .pwr_down(pwr_down),
    .pu_done (pu_done)
  );

  sar_serial_framer #(.FRAME(FRAME), .CW(CW)) u_frm (
    .ser_clk (ser_clk),
    .clr     (clr),
    .start_ok(pu_done),
    .busy    (busy),
    .slot    (slot),
    .start_ev(start_ev)
  );

  sar_serial_sar #(.RES(RES), .LEAD(LEAD), .CW(CW)) u_sar (
    .ser_clk  (ser_clk),
    .clr      (clr),
    .start_ev (start_ev),
    .busy     (busy),
    .slot     (slot),
    .cmp_ge   (cmp_ge),
    .decide_ev(decide_ev),
    .dac_code (dac_code),
    .result   (result)
  );

  sar_serial_shifter u_shf (
    .ser_clk    (ser_clk),
    .clr        (clr),
    .start_ev   (start_ev),
    .decide_ev  (decide_ev),
    .cmp_ge     (cmp_ge),
    .ser_data   (ser_data),
    .ser_data_oe(ser_data_oe)
  );

  assign conv_busy = busy;
  assign sh_hold   = busy;
endmodule

// File: rtl/sar_serial_chk.sv
module sar_serial_chk #(
  parameter int RES  = 12,
  parameter int LEAD = 4,
  parameter int CW   = 4
) (
  input logic           ser_clk,
  input logic           sel_n,
  input logic           pwr_down,
  input logic           conv_busy,
  input logic           sh_hold,
  input logic           ser_data,
  input logic           ser_data_oe,
  input logic [RES-1:0] dac_code,
  input logic [RES-1:0] result,
  input logic [CW-1:0]  slot,
  input logic           pu_done,
  input logic           decide_ev
);
  localparam logic [CW-1:0] LAST_SLOT = CW'(RES + LEAD - 1);
  localparam logic [CW-1:0] LEAD_S    = CW'(LEAD);

  assert_clear_R1: assert property (@(posedge ser_clk)
    (sel_n || pwr_down) |-> (!conv_busy && !sh_hold && !ser_data && !ser_data_oe));

  assert_start_R2: assert property (@(negedge ser_clk) disable iff (sel_n || pwr_down)
    (!conv_busy && pu_done) |=> conv_busy);

  assert_lead_zero_R3: assert property (@(negedge ser_clk) disable iff (sel_n || pwr_down)
    (conv_busy && slot < LEAD_S) |-> !ser_data);

  assert_busy_end_R4: assert property (@(negedge ser_clk) disable iff (sel_n || pwr_down)
    (conv_busy && slot == LAST_SLOT) |=> !conv_busy);

  assert_busy_hold_R4: assert property (@(negedge ser_clk) disable iff (sel_n || pwr_down)
    (conv_busy && slot != LAST_SLOT) |=> conv_busy);

  assert_dead_slot_R5: assert property (@(negedge ser_clk) disable iff (sel_n || pwr_down)
    $fell(conv_busy) |-> (!ser_data && ser_data_oe));

  assert_one_trial_R6: assert property (@(negedge ser_clk) disable iff (sel_n || pwr_down)
    decide_ev |-> ($countones(dac_code ^ result) == 1));

  assert_pwr_wait_R9: assert property (@(negedge ser_clk) disable iff (sel_n || pwr_down)
    !pu_done |-> !conv_busy);

  assert_oe_busy_R10: assert property (@(negedge ser_clk) disable iff (sel_n || pwr_down)
    conv_busy |-> ser_data_oe);
endmodule

bind sar_serial_seq sar_serial_chk #(.RES(RES), .LEAD(LEAD), .CW(CW)) u_chk (
  .ser_clk    (ser_clk),
  .sel_n      (sel_n),
  .pwr_down   (pwr_down),
  .conv_busy  (conv_busy),
  .sh_hold    (sh_hold),
  .ser_data   (ser_data),
  .ser_data_oe(ser_data_oe),
  .dac_code   (dac_code),
  .result     (result),
  .slot       (slot),
  .pu_done    (pu_done),
  .decide_ev  (decide_ev)
);

// File: tb/sim_sar_serial_seq.sv
`timescale 1ns/1ps
module sim_sar_serial_seq;
  localparam int RES = 12;
  localparam int PU  = 8;

  logic           ser_clk = 1'b0;
  logic           sel_n, pwr_down;
  logic           cmp_ge;
  logic [RES-1:0] dac_code;
  logic           ser_data, ser_data_oe, conv_busy, sh_hold;
  logic [RES-1:0] vin;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #4 ser_clk = ~ser_clk;

  // behavioural comparator against the stored input code
  assign cmp_ge = (dac_code <= vin);

  sar_serial_seq #(.RES(RES), .LEAD(4), .PU_CLKS(PU)) u0 (
    .ser_clk(ser_clk), .sel_n(sel_n), .pwr_down(pwr_down), .cmp_ge(cmp_ge),
    .dac_code(dac_code), .ser_data(ser_data), .ser_data_oe(ser_data_oe),
    .conv_busy(conv_busy), .sh_hold(sh_hold)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_cleared(input string req);
    chk(!conv_busy && !sh_hold && !ser_data_oe && !ser_data, req,
        {conv_busy, sh_hold, ser_data_oe, ser_data}, 0);
  endtask

  // Called at the rising edge inside slot 0; ends at the dead-slot rising edge.
  task automatic frame_body(input logic [RES-1:0] v);
    logic [15:0] word = '0;
    for (int k = 0; k < 16; k++) begin
      chk(conv_busy === 1'b1, "R4 busy in slot", conv_busy, 1);
      if (k < 4) chk(ser_data === 1'b0, "R3 lead zero", ser_data, 0);
      if (k >= 3 && k <= 14) begin
        int i = 14 - k;
        int exp_t = ((int'(v) >> (i + 1)) << (i + 1)) | (1 << i);
        chk(int'(dac_code) == exp_t, "R6 trial code", dac_code, exp_t);
      end
      word = {word[14:0], ser_data};
      @(posedge ser_clk);
    end
    chk(conv_busy === 1'b0, "R4 busy falls after 16", conv_busy, 0);
    chk(word == {4'b0, v}, "R7 shifted result", word, {4'b0, v});
  endtask

  task automatic t_reset;
    repeat (2) @(posedge ser_clk);
    check_cleared("R1 reset state");
  endtask

  task automatic t_powerup_edge;
    @(posedge ser_clk); pwr_down = 1'b1; sel_n = 1'b1;
    @(posedge ser_clk); pwr_down = 1'b0; sel_n = 1'b0; vin = 12'h3C3;
    repeat (PU) @(posedge ser_clk);
    chk(conv_busy === 1'b0, "R9 no start inside window", conv_busy, 0);
    @(posedge ser_clk);
    chk(conv_busy === 1'b1, "R9 start at first allowed edge", conv_busy, 1);
    frame_body(12'h3C3);
    sel_n = 1'b1; #1;
    check_cleared("R1 select high");
  endtask

  task automatic t_ignored_start;
    bit seen = 0;
    @(posedge ser_clk); pwr_down = 1'b1;
    @(posedge ser_clk); pwr_down = 1'b0;
    @(posedge ser_clk); sel_n = 1'b0;
    repeat (3) begin
      @(posedge ser_clk);
      if (conv_busy !== 1'b0 || ser_data_oe !== 1'b0) seen = 1;
    end
    sel_n = 1'b1;
    repeat (PU + 2) begin
      @(posedge ser_clk);
      if (conv_busy !== 1'b0) seen = 1;
    end
    chk(!seen, "R9 select pulse in window ignored", seen, 0);
  endtask

  task automatic slave_conv(input logic [RES-1:0] v);
    vin = v;
    @(posedge ser_clk); sel_n = 1'b0;
    @(posedge ser_clk);
    chk(conv_busy && sh_hold, "R2 start after first falling edge", {conv_busy, sh_hold}, 3);
    chk(ser_data_oe === 1'b1, "R10 enable at start", ser_data_oe, 1);
    frame_body(v);
    sel_n = 1'b1; #1;
    check_cleared("R1 deselect");
  endtask

  task automatic t_freerun;
    logic [RES-1:0] vals [3] = '{12'h5A1, 12'hFFE, 12'h001};
    vin = vals[0];
    @(posedge ser_clk); sel_n = 1'b0;
    @(posedge ser_clk);
    for (int f = 0; f < 3; f++) begin
      frame_body(vals[f]);
      chk(ser_data === 1'b0, "R5 dead slot data", ser_data, 0);
      chk(ser_data_oe === 1'b1, "R10 enable in dead slot", ser_data_oe, 1);
      if (f < 2) vin = vals[f + 1];
      @(posedge ser_clk);
      if (f < 2) chk(conv_busy === 1'b1, "R5 restart after one dead clock", conv_busy, 1);
    end
    sel_n = 1'b1; #1;
    check_cleared("R1 end free run");
  endtask

  task automatic t_abort;
    vin = 12'hABC;
    @(posedge ser_clk); sel_n = 1'b0;
    @(posedge ser_clk);
    repeat (6) @(posedge ser_clk);
    chk(conv_busy === 1'b1, "R8 running before abort", conv_busy, 1);
    pwr_down = 1'b1; #1;
    check_cleared("R8 abort on power-down");
    @(posedge ser_clk); pwr_down = 1'b0; sel_n = 1'b1;
    repeat (PU + 2) @(posedge ser_clk);
    slave_conv(12'h123);
  endtask

  initial begin
    sel_n = 1'b0; pwr_down = 1'b0; vin = '0;
    #1 sel_n = 1'b1; pwr_down = 1'b1;
    t_reset();
    t_powerup_edge();
    t_ignored_start();
    slave_conv(12'hA5C);
    slave_conv(12'h000);
    slave_conv(12'hFFF);
    slave_conv(12'h800);
    slave_conv(12'h7FF);
    t_freerun();
    t_abort();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge ser_clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule